// File: doc/BRIEF.md
# Quadrature Up/Down Timer

A 16-bit up/down counter with four count sources, chosen by a mode input. It can step on a divided system-clock tick, on every change of level on an external clock pin, on a tick from a neighbouring timer, or as a 4x decoder for an incremental encoder wired to the same two pins. In the three non-encoder modes, the level of an external direction pin sets whether each event adds or subtracts one.

Both external pins pass through a two-stage synchronizer. Edges are then found by comparing the synchronized level with its value one clock earlier. Software loads the counter with a write strobe, and the write wins over any count event in the same clock. Two sticky flags report a wrap past the top of the range and a wrap past the bottom. They serve as interrupt sources and are cleared by a strobe. There is no data stream, so every pin is a plain level or strobe with no handshake.

Top module: `quad_updown_timer`

## Requirements
- R1: While reset is low, and right after it is released, the count is 0 and both flags are 0.
- R2: With mode_sel = 2'b00, the counter steps once every 2^presc_sel system clocks. It counts up while the synchronized direction pin is 1 and down while it is 0.
- R3: With mode_sel = 2'b01, every rising and every falling change of the synchronized clock pin steps the counter once. The synchronized direction pin gives the direction, as in R2.
- R4: With mode_sel = 2'b10, the state is {clock pin, direction pin}. Each single-bit move along 00→01→11→10→00 adds one, and each move the reverse way subtracts one.
- R5: In the encoder mode, a clock in which both synchronized pins change together leaves the count unchanged.
- R6: With mode_sel = 2'b11, every system clock in which chain_tick is 1 steps the counter once, with direction as in R2.
- R7: A change on an external pin, driven before a rising clock edge, has not changed the count after the second rising edge. It has changed the count after the third.
- R8: An up step from 16'hFFFF gives 0 and sets ovf_flag, which stays set until flag_clr. If a set and a clear fall in the same clock, the set wins.
- R9: A down step from 0 gives 16'hFFFF and sets unf_flag, which holds and clears like ovf_flag.
- R10: When wr_en is 1, the count becomes wr_data on that clock. Any count event in the same clock is dropped and sets no flag.
- R11: Sources that the selected mode does not use (chain_tick, the pins, the prescaler tick) have no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | 00 prescaled, 01 pin edges, 10 encoder, 11 chained |
| presc_sel | input | 3 | Prescaler divide exponent |
| chain_tick | input | 1 | Count pulse from a neighbouring timer |
| ext_clk_pin | input | 1 | External clock pin, encoder phase A |
| ext_dir_pin | input | 1 | External direction pin, encoder phase B |
| wr_en | input | 1 | Load strobe for the count |
| wr_data | input | 16 | Value to load |
| flag_clr | input | 1 | Clears both flags |
| count | output | 16 | Current count |
| ovf_flag | output | 1 | Sticky wrap from top to 0 |
| unf_flag | output | 1 | Sticky wrap from 0 to top |

## Verification
The encoder mode is driven with a random walk of single-phase moves mixed with moves where both phases change. This separates a correct Gray-code direction decode from one that counts any change, and shows that double moves are dropped. In edge mode, random direction levels are paired with random clock toggles, which shows that both edge polarities count and that a direction change alone does not. Prescaled runs at several divide values, with unused sources toggling, pin down the tick rate and show that other sources are ignored. Directed wraps and collisions between a write and a count, or between a flag set and a clear, cover the priorities.

// File: rtl/qtmr_pkg.sv
package qtmr_pkg;
  typedef enum logic [1:0] {
    QM_PRESCALE = 2'b00,
    QM_EDGE     = 2'b01,
    QM_QUAD     = 2'b10,
    QM_CHAIN    = 2'b11
  } qmode_e;
endpackage

// File: rtl/qtmr_sync.sv
module qtmr_sync #(
  parameter int NPIN   = 2,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_i,
  output logic [NPIN-1:0] cur_o,
  output logic [NPIN-1:0] prev_o
);
  // per pin: STAGES metastability flops plus one history flop
  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    logic [STAGES:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-1:0], pin_i[g]};
    end
    assign cur_o[g]  = sh[STAGES-1];
    assign prev_o[g] = sh[STAGES];
  end
endmodule

// File: rtl/qtmr_prescale.sv
module qtmr_prescale #(
  parameter int PW = 8,
  parameter int SW = $clog2(PW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] sel,
  output logic          tick
);
  logic [PW-1:0] cnt;
  logic [PW-1:0] mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  assign mask = ~({PW{1'b1}} << sel);
  assign tick = ((cnt & mask) == mask);
endmodule

// File: rtl/qtmr_decode.sv
module qtmr_decode
  import qtmr_pkg::*;
(
  input  qmode_e     mode,
  input  logic       presc_tick,
  input  logic       chain_tick,
  input  logic [1:0] cur,   // {A = clock pin, B = direction pin}
  input  logic [1:0] prev,
  output logic       inc,
  output logic       dec
);
  always_comb begin
    inc = 1'b0;
    dec = 1'b0;
    unique case (mode)
      QM_PRESCALE: if (presc_tick) begin
        inc = cur[0];
        dec = ~cur[0];
      end
      QM_EDGE: if (cur[1] != prev[1]) begin
        inc = cur[0];
        dec = ~cur[0];
      end
      QM_CHAIN: if (chain_tick) begin
        inc = cur[0];
        dec = ~cur[0];
      end
      QM_QUAD: begin
        case ({prev, cur})
          4'b0001, 4'b0111, 4'b1110, 4'b1000: inc = 1'b1;
          4'b0100, 4'b1101, 4'b1011, 4'b0010: dec = 1'b1;
          default: ;
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/quad_updown_timer.sv
module quad_updown_timer
  import qtmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PRESC_W     = 8,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = $clog2(PRESC_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic [SEL_W-1:0] presc_sel,
  input  logic             chain_tick,
  input  logic             ext_clk_pin,
  input  logic             ext_dir_pin,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count,
  output logic             ovf_flag,
  output logic             unf_flag
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [1:0] pin_cur, pin_prev;
  logic       presc_tick, inc, dec;
  qmode_e     mode;

  assign mode = qmode_e'(mode_sel);

  qtmr_sync #(.NPIN(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .pin_i({ext_clk_pin, ext_dir_pin}),
    .cur_o(pin_cur), .prev_o(pin_prev)
  );

  qtmr_prescale #(.PW(PRESC_W), .SW(SEL_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .sel(presc_sel), .tick(presc_tick)
  );

  qtmr_decode u_dec (
    .mode(mode), .presc_tick(presc_tick), .chain_tick(chain_tick),
    .cur(pin_cur), .prev(pin_prev), .inc(inc), .dec(dec)
  );

  logic step_up, step_dn;
  assign step_up = inc & ~wr_en;
  assign step_dn = dec & ~wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      ovf_flag <= 1'b0;
      unf_flag <= 1'b0;
    end else begin
      if (wr_en)        count <= wr_data;
      else if (step_up) count <= count + 1'b1;
      else if (step_dn) count <= count - 1'b1;
      ovf_flag <= (ovf_flag & ~flag_clr) | (step_up && count == TOP);
      unf_flag <= (unf_flag & ~flag_clr) | (step_dn && count == '0);
    end
  end

  // the load strobe always wins
  assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> count == $past(wr_data));

  // a rising overflow flag must coincide with a top-to-zero wrap
  assert_ovf_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> ($past(count) == TOP && count == '0));

  assert_unf_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unf_flag) |-> ($past(count) == '0 && count == TOP));

  // the decoder never requests both directions at once
  assert_one_direction_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({inc, dec}));

  // without a load, the count moves by at most one per clock
  assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> (count == $past(count) || count == $past(count) + 1'b1
                       || count == $past(count) - 1'b1));
endmodule

// File: tb/sim_quad_updown_timer.sv
module sim_quad_updown_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_sel = 2'b11;
  logic [2:0]  presc_sel = '0;
  logic        chain_tick = 1'b0, ext_clk_pin = 1'b0, ext_dir_pin = 1'b1;
  logic        wr_en = 1'b0, flag_clr = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] count;
  logic        ovf_flag, unf_flag;

  int n_chk = 0, n_bad = 0;
  logic [15:0] exp_cnt;
  logic        exp_ovf, exp_unf;

  always #5 clk = ~clk;

  quad_updown_timer u0 (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .presc_sel(presc_sel),
    .chain_tick(chain_tick), .ext_clk_pin(ext_clk_pin), .ext_dir_pin(ext_dir_pin),
    .wr_en(wr_en), .wr_data(wr_data), .flag_clr(flag_clr),
    .count(count), .ovf_flag(ovf_flag), .unf_flag(unf_flag)
  );

  task automatic nclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic mdl(input bit up);
    if (up) begin
      if (exp_cnt == 16'hFFFF) exp_ovf = 1'b1;
      exp_cnt = exp_cnt + 16'd1;
    end else begin
      if (exp_cnt == 16'h0000) exp_unf = 1'b1;
      exp_cnt = exp_cnt - 16'd1;
    end
  endtask

  // encoder state {A,B}: +1 forward along 00,01,11,10 ; -1 backward ; 0 otherwise
  function automatic int qdelta(input logic [1:0] p, input logic [1:0] c);
    if ((p ^ c) == 2'b01 || (p ^ c) == 2'b10)
      return (c == {p[0], ~p[1]}) ? 1 : -1;
    return 0;
  endfunction

  task automatic load(input logic [15:0] v);
    wr_en = 1'b1; wr_data = v; nclk(1); wr_en = 1'b0;
    exp_cnt = v;
  endtask

  task automatic pulse_clr();
    flag_clr = 1'b1; nclk(1); flag_clr = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    logic [15:0] a;
    logic [1:0]  st;
    void'($urandom(32'h1F2E3D4C));
    nclk(3);
    chk("R1 reset count", count, 16'h0);
    chk("R1 reset flags", {14'b0, ovf_flag, unf_flag}, 16'h0);
    rst_n = 1'b1;
    nclk(4);
    chk("R1 after release", {count[13:0], ovf_flag, unf_flag}, 16'h0);

    // R10: write collides with a chain tick
    wr_en = 1'b1; wr_data = 16'h1234; chain_tick = 1'b1;
    nclk(1); wr_en = 1'b0; chain_tick = 1'b0;
    chk("R10 write beats count", count, 16'h1234);
    // R6 chained mode
    chain_tick = 1'b1; nclk(1); chain_tick = 1'b0;
    chk("R6 chain up", count, 16'h1235);
    ext_dir_pin = 1'b0; nclk(3);
    chain_tick = 1'b1; nclk(5); chain_tick = 1'b0;
    chk("R6 chain down x5", count, 16'h1230);

    // R8 overflow, sticky, clear, set-wins
    ext_dir_pin = 1'b1; nclk(3);
    load(16'hFFFE);
    chain_tick = 1'b1; nclk(2); chain_tick = 1'b0;
    chk("R8 wrap count", count, 16'h0000);
    chk("R8 ovf set", {15'b0, ovf_flag}, 16'h1);
    nclk(3);
    chk("R8 ovf sticky", {15'b0, ovf_flag}, 16'h1);
    pulse_clr();
    chk("R8 ovf cleared", {15'b0, ovf_flag}, 16'h0);
    load(16'hFFFF);
    chain_tick = 1'b1; flag_clr = 1'b1; nclk(1); chain_tick = 1'b0; flag_clr = 1'b0;
    chk("R8 set beats clear", {15'b0, ovf_flag}, 16'h1);
    pulse_clr();
    // R10: write at FFFF with a count pending sets no flag
    load(16'hFFFF);
    wr_en = 1'b1; wr_data = 16'hFFFF; chain_tick = 1'b1; nclk(1);
    wr_en = 1'b0; chain_tick = 1'b0;
    chk("R10 no flag on dropped step", {15'b0, ovf_flag}, 16'h0);

    // R9 underflow
    ext_dir_pin = 1'b0; nclk(3);
    load(16'h0001);
    chain_tick = 1'b1; nclk(2); chain_tick = 1'b0;
    chk("R9 wrap count", count, 16'hFFFF);
    chk("R9 unf set", {15'b0, unf_flag}, 16'h1);
    pulse_clr();
    chk("R9 unf cleared", {15'b0, unf_flag}, 16'h0);

    // R2 prescaled, with R11 unused sources active
    ext_dir_pin = 1'b1; nclk(3);
    mode_sel = 2'b00; presc_sel = 3'd2;
    load(16'd100);
    chk("R10 load in prescale", count, 16'd100);
    a = count; chain_tick = 1'b1;
    for (int i = 0; i < 64; i++) begin
      if (i % 5 == 0) ext_clk_pin = ~ext_clk_pin;
      nclk(1);
    end
    chain_tick = 1'b0;
    chk("R2 R11 div4 over 64", count, a + 16'd16);
    mode_sel = 2'b11; ext_dir_pin = 1'b0; nclk(4);
    mode_sel = 2'b00; presc_sel = 3'd0;
    load(16'd50);
    nclk(10);
    chk("R2 div1 down", count, 16'd40);
    mode_sel = 2'b11; ext_dir_pin = 1'b1; nclk(3);
    mode_sel = 2'b00; presc_sel = 3'd7;
    load(16'd7);
    a = count; nclk(256);
    chk("R2 div128 over 256", count, a + 16'd2);

    // R3 / R7 edge mode, chain_tick ignored (R11)
    mode_sel = 2'b01; chain_tick = 1'b1;
    load(16'd500);
    ext_clk_pin = ~ext_clk_pin;
    nclk(2);
    chk("R7 not yet after two edges", count, 16'd500);
    nclk(1);
    chk("R7 R3 counted after third edge", count, 16'd501);
    ext_clk_pin = ~ext_clk_pin; nclk(3);
    chk("R3 other polarity", count, 16'd502);
    exp_cnt = 16'd502;
    for (int i = 0; i < 40; i++) begin
      bit nd, tg;
      nd = 1'($urandom % 2); tg = 1'($urandom % 2);
      ext_dir_pin = nd;
      if (tg) ext_clk_pin = ~ext_clk_pin;
      nclk(4);
      if (tg) mdl(nd);
      chk("R3 R11 random edge", count, exp_cnt);
    end
    chain_tick = 1'b0;

    // R4 / R5 encoder mode
    mode_sel = 2'b10;
    ext_clk_pin = 1'b0; ext_dir_pin = 1'b0; nclk(4);
    pulse_clr();
    load(16'd2);
    exp_ovf = 1'b0; exp_unf = 1'b0;
    st = 2'b00;
    for (int i = 0; i < 4; i++) begin
      st = {st[0], ~st[1]};
      {ext_clk_pin, ext_dir_pin} = st; nclk(4); mdl(1'b1);
      chk("R4 forward step", count, exp_cnt);
    end
    for (int i = 0; i < 4; i++) begin
      st = {~st[0], st[1]};
      {ext_clk_pin, ext_dir_pin} = st; nclk(4); mdl(1'b0);
      chk("R4 backward step", count, exp_cnt);
    end
    st = ~st; {ext_clk_pin, ext_dir_pin} = st; nclk(4);
    chk("R5 double change ignored", count, exp_cnt);
    for (int i = 0; i < 300; i++) begin
      logic [1:0] nx;
      int d;
      if ($urandom % 5 == 0) nx = ~st;
      else nx = st ^ (($urandom % 2) ? 2'b10 : 2'b01);
      d = qdelta(st, nx);
      st = nx;
      {ext_clk_pin, ext_dir_pin} = st; nclk(4);
      if (d > 0) mdl(1'b1); else if (d < 0) mdl(1'b0);
      chk("R4 R5 random walk", count, exp_cnt);
    end
    chk("R8 R9 flags after walk", {14'b0, ovf_flag, unf_flag}, {14'b0, exp_ovf, exp_unf});

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule